// File: doc/BRIEF.md
# Interrupt Pending and In-Service Tracker

This block keeps the per-vector state a local interrupt controller needs between an interrupt arriving and the processor retiring it. Every vector has three state bits: one that marks it as waiting, one that marks it as being serviced, and one that records whether it last arrived as a level or an edge request. A per-vector enable mask takes vectors out of arbitration without losing their waiting state.

The highest enabled waiting vector is compared against a processor priority class. That class is the larger of a programmable task priority class and the class of the highest vector in service. A vector's class is its upper four bits, and a larger vector number always means higher priority. When the waiting vector wins, the interrupt line to the processor is raised and the acknowledge port shows that vector. Otherwise the acknowledge port shows a programmable spurious vector.

An end-of-interrupt strobe retires the highest vector in service. If that vector was level-triggered, the block requests a broadcast of the retirement together with the vector number.

Top module: `irq_track`

## Requirements
- R1: After reset no vector is waiting, in service or marked level, all vectors are enabled, the task priority is 0 and the spurious vector is 0xFF: `irq` and `eoi_bcast_valid` are 0 and `ack_vec` reads 0xFF.
- R2: A trigger strobe marks its vector as waiting. If that vector is deliverable, `irq` is 1 and `ack_vec` shows it from the first clock edge after the strobe.
- R3: An acknowledge while `irq` is 1 clears the waiting bit of the vector shown on `ack_vec` and sets its in-service bit on the same edge. If that vector is triggered in the same cycle, its waiting bit stays set.
- R4: Among the enabled waiting vectors, the one with the largest number is the candidate presented on `ack_vec`.
- R5: `irq` is 1 only when the candidate's class (bits 7:4) is strictly greater than both the task priority class (bits 7:4 of the value written by `tpr_wr`) and the class of the highest in-service vector. An equal class blocks delivery.
- R6: A mask write loads the enable bits of vectors `mask_sel*32 + i` from `mask_data[i]`. A disabled vector keeps its waiting bit but is left out of arbitration, and it competes again once it is re-enabled.
- R7: An end-of-interrupt strobe clears the in-service bit of the highest in-service vector only. With nothing in service it changes no state and requests no broadcast.
- R8: When the retired vector's trigger-mode bit is 1 (level = 1, edge = 0), `eoi_bcast_valid` is 1 for exactly the one cycle after the end-of-interrupt edge, with that vector on `eoi_bcast_vec`. Edge vectors request no broadcast.
- R9: Each trigger rewrites its vector's trigger-mode bit from `trig_level`, so a level vector retriggered as edge no longer requests a broadcast.
- R10: While `irq` is 0, `ack_vec` shows the spurious vector written with `spur_wr`, and an acknowledge changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger strobe |
| trig_vec | input | 8 | Vector being triggered |
| trig_level | input | 1 | Trigger mode, 1 = level, 0 = edge |
| ack | input | 1 | Processor acknowledge strobe |
| ack_vec | output | 8 | Vector returned on acknowledge |
| irq | output | 1 | Interrupt request to the processor |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_bcast_valid | output | 1 | Broadcast end-of-interrupt request |
| eoi_bcast_vec | output | 8 | Vector of the broadcast request |
| mask_wr | input | 1 | Enable mask group write strobe |
| mask_sel | input | 3 | Group of 32 vectors written |
| mask_data | input | 32 | Enable bits for the group |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_data | input | 8 | Task priority value |
| spur_wr | input | 1 | Spurious vector write strobe |
| spur_data | input | 8 | Spurious vector value |

## Verification
Every stimulus is captured by state registers on one clock edge. `irq` and `ack_vec` are decoded from those registers without further delay, so they are due right after the edge that takes a trigger, acknowledge, mask, priority or end-of-interrupt strobe. The broadcast request has its own register and is also due after that same edge. It must fall again after the following edge. Inputs are driven a short time after each rising edge and held for exactly one edge. The bench samples outputs after that edge has settled, so each check sees the first cycle in which its result is due. The broadcast is also sampled one cycle later to confirm it lasts a single cycle.

// File: rtl/irq_track_pkg.sv
package irq_track_pkg;
  // Number of upper vector bits that form the priority class
  parameter int CLASS_W = 4;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_bitvec.sv
// One state bit per vector with single-index set/clear and a group load.
// Precedence inside one cycle: group load, then clear, then set.
module irq_bitvec #(
  parameter int N       = 256,
  parameter int GRP     = 32,
  parameter bit RST_VAL = 1'b0,
  parameter int IW      = $clog2(N),
  parameter int NG      = N / GRP,
  parameter int GSW     = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_en,
  input  logic [IW-1:0]  set_idx,
  input  logic           clr_en,
  input  logic [IW-1:0]  clr_idx,
  input  logic           grp_wr,
  input  logic [GSW-1:0] grp_sel,
  input  logic [GRP-1:0] grp_data,
  output logic [N-1:0]   q
);
  localparam int GW = (GRP > 1) ? $clog2(GRP) : 1;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GRP-1:0] bits_q;
    logic [GRP-1:0] bits_d;
    logic           grp_hit;
    logic           set_hit;
    logic           clr_hit;
    logic           bits_en;

    assign grp_hit = grp_wr && (grp_sel == GSW'(g));
    assign set_hit = set_en && ((set_idx >> GW) == IW'(g));
    assign clr_hit = clr_en && ((clr_idx >> GW) == IW'(g));
    assign bits_en = grp_hit || set_hit || clr_hit;

    always_comb begin
      bits_d = bits_q;
      if (grp_hit) bits_d = grp_data;
      for (int i = 0; i < GRP; i++) begin
        if (clr_en && (clr_idx == IW'(g * GRP + i))) bits_d[i] = 1'b0;
        if (set_en && (set_idx == IW'(g * GRP + i))) bits_d[i] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bits_q <= {GRP{RST_VAL}};
      else if (bits_en) bits_q <= bits_d;
    end

    assign q[g*GRP +: GRP] = bits_q;
  end
endmodule

// File: rtl/irq_find_top.sv
// Two-level search for the highest set bit: per group, then across groups.
module irq_find_top #(
  parameter int N   = 256,
  parameter int GRP = 32,
  parameter int IW  = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] idx
);
  localparam int NG = N / GRP;
  localparam int GW = (GRP > 1) ? $clog2(GRP) : 1;

  logic [NG-1:0]    g_any;
  logic [NG*GW-1:0] g_idx;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic          any_l;
    logic [GW-1:0] idx_l;

    always_comb begin
      any_l = 1'b0;
      idx_l = '0;
      for (int i = 0; i < GRP; i++) begin
        if (bits[g*GRP + i]) begin
          any_l = 1'b1;
          idx_l = GW'(i);
        end
      end
    end

    assign g_any[g]           = any_l;
    assign g_idx[g*GW +: GW]  = idx_l;
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int g = 0; g < NG; g++) begin
      if (g_any[g]) begin
        any = 1'b1;
        idx = IW'(g * GRP) + IW'(g_idx[g*GW +: GW]);
      end
    end
  end
endmodule

// File: rtl/irq_track.sv
module irq_track #(
  parameter int          NUM_VEC  = 256,
  parameter int          MASK_GRP = 32,
  parameter logic [7:0]  SPUR_RST = 8'hFF,
  parameter int          VEC_W    = $clog2(NUM_VEC),
  parameter int          GSW      = ((NUM_VEC / MASK_GRP) > 1) ? $clog2(NUM_VEC / MASK_GRP) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_valid,
  input  logic [VEC_W-1:0]    trig_vec,
  input  logic                trig_level,
  input  logic                ack,
  output logic [VEC_W-1:0]    ack_vec,
  output logic                irq,
  input  logic                eoi,
  output logic                eoi_bcast_valid,
  output logic [VEC_W-1:0]    eoi_bcast_vec,
  input  logic                mask_wr,
  input  logic [GSW-1:0]      mask_sel,
  input  logic [MASK_GRP-1:0] mask_data,
  input  logic                tpr_wr,
  input  logic [VEC_W-1:0]    tpr_data,
  input  logic                spur_wr,
  input  logic [VEC_W-1:0]    spur_data
);
  import irq_track_pkg::*;

  localparam int CW = CLASS_W;

  // Per-vector state arrays
  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] isr_q;
  logic [NUM_VEC-1:0] tmr_q;
  logic [NUM_VEC-1:0] en_q;

  // Arbitration results
  logic             p_any;
  logic [VEC_W-1:0] p_idx;
  logic             s_any;
  logic [VEC_W-1:0] s_idx;
  logic [CW-1:0]    p_cls;
  logic [CW-1:0]    s_cls;
  logic [CW-1:0]    t_cls;
  logic [CW-1:0]    ppr_cls;
  logic             deliver;
  logic             take;
  logic             retire;

  // Scalar registers
  logic [VEC_W-1:0] tpr_q, tpr_d;
  logic [VEC_W-1:0] spur_q, spur_d;
  logic             bc_valid_q, bc_valid_d;
  logic [VEC_W-1:0] bc_vec_q, bc_vec_d;

  irq_find_top #(.N(NUM_VEC), .GRP(MASK_GRP), .IW(VEC_W)) u_find_pend (
    .bits (pend_q & en_q),
    .any  (p_any),
    .idx  (p_idx)
  );

  irq_find_top #(.N(NUM_VEC), .GRP(MASK_GRP), .IW(VEC_W)) u_find_isr (
    .bits (isr_q),
    .any  (s_any),
    .idx  (s_idx)
  );

  // Priority decision
  always_comb begin
    p_cls   = p_idx[VEC_W-1 -: CW];
    s_cls   = s_any ? s_idx[VEC_W-1 -: CW] : '0;
    t_cls   = tpr_q[VEC_W-1 -: CW];
    ppr_cls = (t_cls > s_cls) ? t_cls : s_cls;
    deliver = p_any && (p_cls > ppr_cls);
  end

  assign take    = ack && deliver;
  assign retire  = eoi && s_any;
  assign irq     = deliver;
  assign ack_vec = deliver ? p_idx : spur_q;

  irq_bitvec #(.N(NUM_VEC), .GRP(MASK_GRP), .RST_VAL(1'b0), .IW(VEC_W), .GSW(GSW)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (trig_valid),
    .set_idx  (trig_vec),
    .clr_en   (take),
    .clr_idx  (p_idx),
    .grp_wr   (1'b0),
    .grp_sel  ('0),
    .grp_data ('0),
    .q        (pend_q)
  );

  irq_bitvec #(.N(NUM_VEC), .GRP(MASK_GRP), .RST_VAL(1'b0), .IW(VEC_W), .GSW(GSW)) u_isr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (take),
    .set_idx  (p_idx),
    .clr_en   (retire),
    .clr_idx  (s_idx),
    .grp_wr   (1'b0),
    .grp_sel  ('0),
    .grp_data ('0),
    .q        (isr_q)
  );

  irq_bitvec #(.N(NUM_VEC), .GRP(MASK_GRP), .RST_VAL(1'b0), .IW(VEC_W), .GSW(GSW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (trig_valid && (trig_level == TRIG_LEVEL)),
    .set_idx  (trig_vec),
    .clr_en   (trig_valid && (trig_level == TRIG_EDGE)),
    .clr_idx  (trig_vec),
    .grp_wr   (1'b0),
    .grp_sel  ('0),
    .grp_data ('0),
    .q        (tmr_q)
  );

  irq_bitvec #(.N(NUM_VEC), .GRP(MASK_GRP), .RST_VAL(1'b1), .IW(VEC_W), .GSW(GSW)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (1'b0),
    .set_idx  ('0),
    .clr_en   (1'b0),
    .clr_idx  ('0),
    .grp_wr   (mask_wr),
    .grp_sel  (mask_sel),
    .grp_data (mask_data),
    .q        (en_q)
  );

  // Next state of scalar registers
  always_comb begin
    tpr_d      = tpr_wr  ? tpr_data  : tpr_q;
    spur_d     = spur_wr ? spur_data : spur_q;
    bc_valid_d = retire && tmr_q[s_idx];
    bc_vec_d   = s_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q  <= '0;
      spur_q <= SPUR_RST[VEC_W-1:0];
    end else begin
      if (tpr_wr)  tpr_q  <= tpr_d;
      if (spur_wr) spur_q <= spur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_valid_q <= 1'b0;
      bc_vec_q   <= '0;
    end else begin
      bc_valid_q <= bc_valid_d;
      if (bc_valid_d) bc_vec_q <= bc_vec_d;
    end
  end

  assign eoi_bcast_valid = bc_valid_q;
  assign eoi_bcast_vec   = bc_vec_q;
endmodule

// File: rtl/irq_track_chk.sv
module irq_track_chk #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trig_valid,
  input logic               ack,
  input logic               eoi,
  input logic               irq,
  input logic [VEC_W-1:0]   ack_vec,
  input logic               eoi_bcast_valid,
  input logic [VEC_W-1:0]   tpr_q,
  input logic [NUM_VEC-1:0] pend_q,
  input logic [NUM_VEC-1:0] isr_q
);
  // R5: delivery needs a class above the task priority class
  assert_irq_above_tpr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ack_vec[VEC_W-1 -: 4] > tpr_q[VEC_W-1 -: 4]));

  // R3: an accepted acknowledge leaves the vector in service
  assert_ack_sets_isr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> isr_q[$past(ack_vec)]);

  // R8: a broadcast only follows an end-of-interrupt strobe
  assert_bcast_after_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_valid |-> $past(eoi));

  // R10: an acknowledge without delivery leaves the arrays alone
  assert_spurious_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !trig_valid && !eoi) |=> ($stable(pend_q) && $stable(isr_q)));

  // R7: end-of-interrupt with nothing in service is a no-op
  assert_eoi_empty_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (isr_q == '0) && !ack) |=> ((isr_q == '0) && !eoi_bcast_valid));
endmodule

bind irq_track irq_track_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .trig_valid      (trig_valid),
  .ack             (ack),
  .eoi             (eoi),
  .irq             (irq),
  .ack_vec         (ack_vec),
  .eoi_bcast_valid (eoi_bcast_valid),
  .tpr_q           (tpr_q),
  .pend_q          (pend_q),
  .isr_q           (isr_q)
);

// File: tb/sim_irq_track.sv
`timescale 1ns/1ps
module sim_irq_track;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_valid, trig_level, ack, eoi, mask_wr, tpr_wr, spur_wr;
  logic [7:0]  trig_vec, tpr_data, spur_data, ack_vec, eoi_bcast_vec;
  logic [2:0]  mask_sel;
  logic [31:0] mask_data;
  logic        irq, eoi_bcast_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_track u0 (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_vec(trig_vec), .trig_level(trig_level),
    .ack(ack), .ack_vec(ack_vec), .irq(irq),
    .eoi(eoi), .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vec(eoi_bcast_vec),
    .mask_wr(mask_wr), .mask_sel(mask_sel), .mask_data(mask_data),
    .tpr_wr(tpr_wr), .tpr_data(tpr_data), .spur_wr(spur_wr), .spur_data(spur_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    trig_valid = 0; trig_level = 0; trig_vec = 0; ack = 0; eoi = 0;
    mask_wr = 0; mask_sel = 0; mask_data = 0;
    tpr_wr = 0; tpr_data = 0; spur_wr = 0; spur_data = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    cyc(); cyc();
    rst_n = 1;
    cyc();
  endtask

  task automatic trig(input logic [7:0] v, input logic lvl);
    trig_valid = 1; trig_vec = v; trig_level = lvl;
    cyc();
    trig_valid = 0;
  endtask

  task automatic do_ack();
    ack = 1; cyc(); ack = 0;
  endtask

  task automatic do_eoi();
    eoi = 1; cyc(); eoi = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq", irq, 0);
    chk("R1 ack_vec", ack_vec, 8'hFF);
    chk("R1 bcast", eoi_bcast_valid, 0);
  endtask

  task automatic t_basic();
    do_reset();
    trig(8'h35, 0);
    chk("R2 irq", irq, 1);
    chk("R2 ack_vec", ack_vec, 8'h35);
    do_ack();
    chk("R3 irq after ack", irq, 0);
    trig(8'h31, 0);
    chk("R3/R5 class 3 in service blocks 0x31", irq, 0);
    trig(8'h45, 0);
    chk("R5 higher class delivers", ack_vec, 8'h45);
    // R3: trigger and acknowledge of the same vector in one cycle
    trig_valid = 1; trig_vec = 8'h45; trig_level = 0; ack = 1;
    cyc();
    trig_valid = 0; ack = 0;
    chk("R3 pending kept on same-cycle retrigger irq", irq, 0);
    do_eoi();
    chk("R3 retriggered 0x45 delivers after eoi", ack_vec, 8'h45);
  endtask

  task automatic t_priority();
    do_reset();
    trig(8'h62, 0);
    trig(8'h91, 0);
    trig(8'h7F, 0);
    chk("R4 highest wins", ack_vec, 8'h91);
    do_ack();
    chk("R4 0x7F blocked by in-service 0x91", irq, 0);
  endtask

  task automatic t_tpr();
    do_reset();
    tpr_wr = 1; tpr_data = 8'h50; cyc(); tpr_wr = 0;
    trig(8'h5A, 0);
    chk("R5 equal class to tpr blocked", irq, 0);
    trig(8'h60, 0);
    chk("R5 above tpr delivered", ack_vec, 8'h60);
    tpr_wr = 1; tpr_data = 8'h6F; cyc(); tpr_wr = 0;
    chk("R5 raised tpr blocks", irq, 0);
    chk("R5 spurious shown", ack_vec, 8'hFF);
  endtask

  task automatic t_isr_eoi();
    do_reset();
    trig(8'h80, 0);
    do_ack();
    trig(8'h8F, 0);
    chk("R5 same class as isr blocked", irq, 0);
    trig(8'h95, 0);
    chk("R5 higher than isr", ack_vec, 8'h95);
    do_ack();
    do_eoi();
    chk("R7 eoi retires only 0x95", irq, 0);
    do_eoi();
    chk("R7 second eoi retires 0x80", ack_vec, 8'h8F);
    chk("R7 irq after second eoi", irq, 1);
  endtask

  task automatic t_mask();
    do_reset();
    trig(8'hA3, 0);
    mask_wr = 1; mask_sel = 3'd5; mask_data = 32'hFFFF_FFF7; cyc(); mask_wr = 0;
    chk("R6 disabled vector removed", irq, 0);
    trig(8'h44, 0);
    chk("R6 enabled lower vector delivers", ack_vec, 8'h44);
    mask_wr = 1; mask_sel = 3'd5; mask_data = 32'hFFFF_FFFF; cyc(); mask_wr = 0;
    chk("R6 re-enabled vector competes", ack_vec, 8'hA3);
  endtask

  task automatic t_bcast();
    do_reset();
    trig(8'h40, 1);
    do_ack();
    do_eoi();
    chk("R8 bcast valid", eoi_bcast_valid, 1);
    chk("R8 bcast vector", eoi_bcast_vec, 8'h40);
    cyc();
    chk("R8 bcast one cycle", eoi_bcast_valid, 0);
    trig(8'h40, 0);
    do_ack();
    do_eoi();
    chk("R9 edge retrigger no bcast", eoi_bcast_valid, 0);
    trig(8'h52, 0);
    do_ack();
    do_eoi();
    chk("R8 edge vector no bcast", eoi_bcast_valid, 0);
  endtask

  task automatic t_eoi_empty();
    do_reset();
    trig(8'h30, 0);
    do_eoi();
    chk("R7 empty eoi no bcast", eoi_bcast_valid, 0);
    chk("R7 empty eoi keeps pending", ack_vec, 8'h30);
  endtask

  task automatic t_spur();
    do_reset();
    spur_wr = 1; spur_data = 8'h27; cyc(); spur_wr = 0;
    chk("R10 spurious value", ack_vec, 8'h27);
    tpr_wr = 1; tpr_data = 8'h70; cyc(); tpr_wr = 0;
    trig(8'h66, 0);
    do_ack();
    chk("R10 ack without irq returns spurious", ack_vec, 8'h27);
    tpr_wr = 1; tpr_data = 8'h00; cyc(); tpr_wr = 0;
    chk("R10 pending untouched by spurious ack", ack_vec, 8'h66);
    do_eoi();
    chk("R10 nothing put in service", eoi_bcast_valid, 0);
    chk("R10 still pending after eoi", irq, 1);
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle();
    #2;
    t_reset();
    t_basic();
    t_priority();
    t_tpr();
    t_isr_eoi();
    t_mask();
    t_bcast();
    t_eoi_empty();
    t_spur();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule